// File: doc/BRIEF.md
# Light-Load Skip Mode Controller

This block sits in each channel of a synchronous step-down converter and decides, cycle by cycle, whether the channel runs fixed-frequency pulse-width modulation or pulse skipping. It issues the high-side on request and the low-side enable. All analog decisions (the zero-crossing comparator on the low-side switch, the skip peak-current comparator, the PWM comparator and the three output-voltage window comparators) reach it as flags already synchronised to its clock. A single-cycle strobe marks the start of each switching period.

In PWM operation the high side is requested at each strobe and released when the PWM comparator trips. The low side then conducts for the rest of the period, even after the inductor current reverses. A counter tracks how many consecutive switching periods contained a low-side zero crossing. Once that run reaches its configured length with the mode-select input asking for light-load operation, the channel switches to skip operation. In skip operation each strobe starts a high-side pulse that ends on the peak-current flag. The low side is cut off at the first zero crossing so that no reverse current flows. An overshoot above the upper window parks the channel idle until the output has fallen back to nominal. An undershoot below the lower window, or selecting forced PWM, returns the channel to PWM.

Top module: `skip_mode_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, hs_on is 0, ls_en is 1 and skip_act is 0.
- R2: Outside skip operation, the clock after a cyc_start hs_on is 1. The clock after a pwm_trip with no cyc_start, hs_on is 0. ls_en equals the inverse of hs_on, so a zero crossing does not turn the low side off.
- R3: With force_pwm at 0, skip_act rises the clock after the RUN_LEN-th consecutive cyc_start (16 by default) at which a zero crossing had been flagged since the previous cyc_start, counting the strobe cycle itself. A cyc_start with no such crossing restarts the run from zero.
- R4: In skip operation, a cyc_start sets hs_on on the next clock unless the channel is parked. A pk_flag clears hs_on on the next clock.
- R5: In skip operation, ov_hi clears hs_on on the next clock and parks the channel. While parked, cyc_start does not set hs_on as long as at_nom is 1. The first cyc_start that arrives with at_nom at 0 ends the park and sets hs_on again.
- R6: In skip operation, a zc_flag while hs_on is 0 drives ls_en to 0 from the next clock until hs_on is next set.
- R7: In skip operation, uv_lo returns the channel to PWM on the next clock (skip_act 0, hs_on 0 until the next cyc_start) and restarts the crossing run from zero.
- R8: While force_pwm is 1 the crossing run is held at zero, so no skip entry occurs. If skip operation is active when force_pwm rises, it ends at the next cyc_start, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock strobe opening each switching period |
| force_pwm | input | 1 | Mode select: 1 forces PWM, 0 allows skip operation |
| pwm_trip | input | 1 | PWM comparator result, ends the high-side pulse in PWM |
| zc_flag | input | 1 | Low-side current zero-crossing flag |
| pk_flag | input | 1 | Skip peak-current comparator flag |
| ov_hi | input | 1 | Output above the upper window edge |
| at_nom | input | 1 | Output at or above nominal |
| uv_lo | input | 1 | Output below the lower window edge |
| hs_on | output | 1 | High-side on request |
| ls_en | output | 1 | Low-side enable |
| skip_act | output | 1 | Skip operation active |

## Verification
The bench builds the block with its default run length of 16 and the variant that latches a crossing seen anywhere in a period until the next strobe. The full-length run therefore exercises the counter's terminal value, including a run that stops one strobe short and a run that a single missing crossing breaks. It also covers crossings flagged at different offsets inside a period. With an eight-clock period, every skip sub-case fits in a few hundred clocks: entry, peak termination, low-side cut-off, overshoot park and release, undershoot exit and a deferred forced-PWM exit.

// File: rtl/skip_ctrl_pkg.sv
package skip_ctrl_pkg;

   typedef enum logic {
      MODE_PWM  = 1'b0,
      MODE_SKIP = 1'b1
   } op_mode_e;

   function automatic int unsigned run_cnt_width(input int unsigned run_len);
      return (run_len < 2) ? 1 : $clog2(run_len);
   endfunction

endpackage

// File: rtl/zc_run_counter.sv
module zc_run_counter #(
   parameter int unsigned RUN_LEN  = 16,
   parameter bit          LATCH_ZC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic zc_flag,
   input  logic count_en,
   output logic run_done
);
   localparam int unsigned CNT_W = skip_ctrl_pkg::run_cnt_width(RUN_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

   if (RUN_LEN < 2) begin : g_bad_len
      $error("zc_run_counter: RUN_LEN must be at least 2");
   end

   logic             crossed;
   logic [CNT_W-1:0] cnt_q;

   if (LATCH_ZC) begin : g_latched
      logic seen_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      seen_q <= 1'b0;
         else if (strobe) seen_q <= 1'b0;
         else if (zc_flag) seen_q <= 1'b1;
      end
      assign crossed = seen_q | zc_flag;
   end else begin : g_direct
      assign crossed = zc_flag;
   end

   assign run_done = count_en & strobe & crossed & (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!count_en)         cnt_q <= '0;
      else if (strobe) begin
         if (!crossed || run_done) cnt_q <= '0;
         else                      cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_MISS_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && strobe && !crossed) |=> (cnt_q == '0)); // R3
   AST_FORCED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/pwm_gate.sv
module pwm_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic strobe,
   input  logic trip,
   output logic hs_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       hs_q <= 1'b0;
      else if (!active) hs_q <= 1'b0;
      else if (strobe)  hs_q <= 1'b1;
      else if (trip)    hs_q <= 1'b0;
   end

   AST_PWM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && strobe) |=> hs_q); // R2
   AST_PWM_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && trip && !strobe) |=> !hs_q); // R2

endmodule

// File: rtl/skip_regulator.sv
module skip_regulator (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic strobe,
   input  logic pk_flag,
   input  logic zc_flag,
   input  logic ov_hi,
   input  logic at_nom,
   output logic hs_q,
   output logic ls_blk_q
);
   logic park_q, park_d, hs_d, blk_d;

   always_comb begin
      park_d = park_q;
      if (ov_hi)                  park_d = 1'b1;
      else if (park_q && !at_nom) park_d = 1'b0;

      hs_d = hs_q;
      if (ov_hi)                  hs_d = 1'b0;
      else if (strobe && !park_d) hs_d = 1'b1;
      else if (pk_flag)           hs_d = 1'b0;

      blk_d = ls_blk_q;
      if (hs_d)         blk_d = 1'b0;
      else if (zc_flag) blk_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         park_q   <= 1'b0;
         hs_q     <= 1'b0;
         ls_blk_q <= 1'b0;
      end else begin
         park_q   <= park_d;
         hs_q     <= hs_d;
         ls_blk_q <= blk_d;
      end
   end

   AST_OV_KILLS_HS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ov_hi) |=> !hs_q); // R5
   AST_PARK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && park_q && at_nom) |=> !hs_q); // R5
   AST_PK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && pk_flag && !strobe) |=> !hs_q); // R4
   AST_ZC_CUTS_LS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && zc_flag && !strobe && !hs_q) |=> ls_blk_q); // R6

endmodule

// File: rtl/skip_mode_ctrl.sv
module skip_mode_ctrl #(
   parameter int unsigned RUN_LEN  = 16,
   parameter bit          LATCH_ZC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic force_pwm,
   input  logic pwm_trip,
   input  logic zc_flag,
   input  logic pk_flag,
   input  logic ov_hi,
   input  logic at_nom,
   input  logic uv_lo,
   output logic hs_on,
   output logic ls_en,
   output logic skip_act
);
   import skip_ctrl_pkg::*;

   if (RUN_LEN < 2) begin : g_bad_len
      $error("skip_mode_ctrl: RUN_LEN must be at least 2");
   end

   op_mode_e mode_q, mode_d;
   logic     run_done, count_en;
   logic     pwm_hs, skip_hs, skip_blk;

   assign count_en = (mode_q == MODE_PWM) && !force_pwm;

   zc_run_counter #(
      .RUN_LEN  (RUN_LEN),
      .LATCH_ZC (LATCH_ZC)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (cyc_start),
      .zc_flag  (zc_flag),
      .count_en (count_en),
      .run_done (run_done)
   );

   always_comb begin
      mode_d = mode_q;
      case (mode_q)
         MODE_PWM:  if (run_done) mode_d = MODE_SKIP;
         MODE_SKIP: if (uv_lo || (force_pwm && cyc_start)) mode_d = MODE_PWM;
         default:   mode_d = MODE_PWM;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= MODE_PWM;
      else        mode_q <= mode_d;
   end

   pwm_gate u_pwm (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (mode_d == MODE_PWM),
      .strobe (cyc_start),
      .trip   (pwm_trip),
      .hs_q   (pwm_hs)
   );

   skip_regulator u_skip (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (mode_d == MODE_SKIP),
      .strobe   (cyc_start),
      .pk_flag  (pk_flag),
      .zc_flag  (zc_flag),
      .ov_hi    (ov_hi),
      .at_nom   (at_nom),
      .hs_q     (skip_hs),
      .ls_blk_q (skip_blk)
   );

   assign hs_on    = pwm_hs | skip_hs;
   assign ls_en    = !hs_on && !skip_blk;
   assign skip_act = (mode_q == MODE_SKIP);

   AST_ENTRY_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(skip_act) |-> ($past(cyc_start) && !$past(force_pwm))); // R3
   AST_UV_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_act && uv_lo) |=> !skip_act); // R7
   AST_FORCE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_act && force_pwm && cyc_start) |=> !skip_act); // R8
   AST_FORCE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_act && !cyc_start && !uv_lo) |=> skip_act); // R8
   AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_hs && skip_hs)); // R2

endmodule

// File: tb/skip_mode_ctrl_tb.sv
module skip_mode_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int RUN = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 0, force_pwm = 0, pwm_trip = 0, zc_flag = 0;
   logic pk_flag = 0, ov_hi = 0, at_nom = 0, uv_lo = 0;
   logic hs_on, ls_en, skip_act;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   skip_mode_ctrl #(.RUN_LEN(RUN), .LATCH_ZC(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .force_pwm(force_pwm),
      .pwm_trip(pwm_trip), .zc_flag(zc_flag), .pk_flag(pk_flag), .ov_hi(ov_hi),
      .at_nom(at_nom), .uv_lo(uv_lo), .hs_on(hs_on), .ls_en(ls_en), .skip_act(skip_act)
   );

   // behavioural reference: mode flag, run length, and the skip pulse bookkeeping
   bit m_skip, m_seen, m_hs_pwm, m_hs_skip, m_cut, m_park;
   int m_run;

   always @(posedge clk) begin
      bit crossed, next_skip;
      if (!rst_n) begin
         m_skip = 0; m_seen = 0; m_hs_pwm = 0; m_hs_skip = 0; m_cut = 0; m_park = 0; m_run = 0;
      end else begin
         crossed = m_seen || zc_flag;
         next_skip = m_skip;
         if (m_skip || force_pwm) m_run = 0;
         else if (cyc_start) begin
            m_run = crossed ? m_run + 1 : 0;
            if (m_run == RUN) begin next_skip = 1; m_run = 0; end
         end
         if (m_skip && (uv_lo || (force_pwm && cyc_start))) next_skip = 0;
         m_seen = cyc_start ? 0 : (m_seen || zc_flag);
         if (next_skip) begin
            m_hs_pwm = 0;
            if (ov_hi) m_park = 1;
            else if (m_park && !at_nom) m_park = 0;
            if (ov_hi) m_hs_skip = 0;
            else if (cyc_start && !m_park) m_hs_skip = 1;
            else if (pk_flag) m_hs_skip = 0;
            if (m_hs_skip) m_cut = 0;
            else if (zc_flag) m_cut = 1;
         end else begin
            m_hs_skip = 0; m_cut = 0; m_park = 0;
            if (cyc_start) m_hs_pwm = 1;
            else if (pwm_trip) m_hs_pwm = 0;
         end
         m_skip = next_skip;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit e_hs, e_ls;
         e_hs = m_hs_pwm || m_hs_skip;
         e_ls = !e_hs && !m_cut;
         checks++;
         if (hs_on !== e_hs || ls_en !== e_ls || skip_act !== m_skip) begin
            errors++;
            $display("FAIL %s model: hs_on=%b ls_en=%b skip_act=%b expected %b %b %b at %0t",
                     cur_req, hs_on, ls_en, skip_act, e_hs, e_ls, m_skip, $time);
         end
      end
   end

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic run_cyc(input int zc_at, input int pk_at, input int tr_at,
                          input int ov_at, input int uv_at);
      for (int i = 0; i < 8; i++) begin
         @(posedge clk); #2;
         cyc_start = (i == 0);
         zc_flag   = (i == zc_at);
         pk_flag   = (i == pk_at);
         pwm_trip  = (i == tr_at);
         ov_hi     = (i == ov_at);
         uv_lo     = (i == uv_at);
      end
   endtask

   task automatic idle();
      @(posedge clk); #2;
      cyc_start = 0; zc_flag = 0; pk_flag = 0; pwm_trip = 0; ov_hi = 0; uv_lo = 0;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", hs_on, 1'b0, "hs_on in reset");
      chk("R1", ls_en, 1'b1, "ls_en in reset");
      chk("R1", skip_act, 1'b0, "skip_act in reset");
      @(posedge clk); #2; rst_n = 1;
      @(negedge clk);
      chk("R1", skip_act, 1'b0, "skip_act after reset");

      cur_req = "R8";
      force_pwm = 1;
      for (int c = 0; c < 20; c++) run_cyc(5, -1, 3, -1, -1);
      idle();
      chk("R8", skip_act, 1'b0, "no entry while forced");
      chk("R2", ls_en, 1'b1, "low side kept after crossing in PWM");
      chk("R2", hs_on, 1'b0, "trip ended pulse");

      cur_req = "R3";
      force_pwm = 0;
      for (int c = 0; c < 3; c++) run_cyc(5, -1, 3, -1, -1);
      run_cyc(-1, -1, 3, -1, -1);
      for (int c = 0; c < RUN; c++) run_cyc((c % 2) ? 7 : 4, -1, 3, -1, -1);
      idle();
      chk("R3", skip_act, 1'b0, "run one short");
      run_cyc(5, 2, 3, -1, -1);
      idle();
      chk("R3", skip_act, 1'b1, "entry after full run");
      chk("R4", hs_on, 1'b0, "peak ended skip pulse");
      chk("R6", ls_en, 1'b0, "low side cut after crossing");

      cur_req = "R4";
      run_cyc(-1, -1, 2, -1, -1);
      idle();
      chk("R4", hs_on, 1'b1, "strobe starts skip pulse, trip ignored");
      run_cyc(6, 3, -1, -1, -1);
      idle();
      chk("R4", hs_on, 1'b0, "peak flag ends pulse");
      chk("R6", ls_en, 1'b0, "cut after crossing");

      cur_req = "R5";
      at_nom = 1;
      run_cyc(5, -1, -1, 2, -1);
      idle();
      chk("R5", hs_on, 1'b0, "overshoot forces off");
      run_cyc(-1, -1, -1, -1, -1);
      idle();
      chk("R5", hs_on, 1'b0, "parked while at nominal");
      chk("R5", skip_act, 1'b1, "still skipping while parked");
      at_nom = 0;
      run_cyc(-1, -1, -1, -1, -1);
      idle();
      chk("R5", hs_on, 1'b1, "park released below nominal");

      cur_req = "R7";
      run_cyc(5, -1, -1, -1, 3);
      idle();
      chk("R7", skip_act, 1'b0, "undershoot returns to PWM");
      chk("R7", hs_on, 1'b0, "no pulse until next strobe");
      chk("R7", ls_en, 1'b1, "low side enabled in PWM");

      cur_req = "R8";
      for (int c = 0; c < RUN + 1; c++) run_cyc(5, 2, 3, -1, -1);
      idle();
      chk("R8", skip_act, 1'b1, "re-entered skip");
      force_pwm = 1;
      idle();
      idle();
      chk("R8", skip_act, 1'b1, "forced exit waits for strobe");
      run_cyc(-1, -1, -1, -1, -1);
      idle();
      chk("R8", skip_act, 1'b0, "forced exit at strobe");
      chk("R2", hs_on, 1'b1, "PWM strobe starts pulse");

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule